// File: doc/BRIEF.md
# Push-Button Byte Memory Editor

This block lets an operator browse and modify a small on-chip byte memory with four push buttons and read the result on seven-segment digits. One pair of buttons moves a selection pointer forward or backward through the locations. The other pair adds one to or subtracts one from the byte held at the selected location. Three digit outputs show the pointer and the selected byte in hexadecimal.

Button inputs must already be debounced and synchronous to `clk`. A press takes effect once, on the first clock edge at which its level is seen high, and only when it is the sole button held. When the pointer moves, the byte on the display is loaded from the new location. An edit updates the display and writes the new byte back in the same edge.

The depth and the byte width are parameters. The number of digits follows from them, one digit per four bits. Segment polarity is selected by a parameter.

Top module: `memedit_top`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the pointer, every memory location and the displayed byte are zero.
- R2: A press of `btn_addr_up` raises the pointer by one at the next clock edge, wrapping from the last location (F) to 0.
- R3: A press of `btn_addr_dn` lowers the pointer by one at the next clock edge, wrapping from 0 to the last location (F).
- R4: After any pointer step, the displayed byte equals the byte stored at the newly selected location.
- R5: A press of `btn_val_up` adds one to the displayed byte, wrapping FF to 00, and stores the result at the selected location in the same clock edge.
- R6: A press of `btn_val_dn` subtracts one from the displayed byte, wrapping 00 to FF, and stores the result at the selected location in the same clock edge.
- R7: A button acts once per press, at the edge where its level is first high. Holding it for further cycles changes nothing.
- R8: A button acts only if no other button is high in that cycle. Pressing two at once changes nothing, and so does pressing one while another is held.
- R9: A button that is already high when reset ends does not act until it has been released and pressed again.
- R10: Each digit is 7 bits with bit 0 = segment a through bit 6 = segment g, 1 = lit with default polarity. The hex glyphs, written as g..a, are 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 b=7C C=39 d=5E E=79 F=71. `seg_val[6:0]` shows the low nibble and `seg_val[13:7]` the high nibble. The digits follow the state with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_addr_up | input | 1 | Move the pointer forward (debounced level) |
| btn_addr_dn | input | 1 | Move the pointer backward (debounced level) |
| btn_val_up | input | 1 | Add one to the selected byte (debounced level) |
| btn_val_dn | input | 1 | Subtract one from the selected byte (debounced level) |
| seg_addr | output | ADDR_DIGITS*7 (7) | Pointer digit(s), segments a..g |
| seg_val | output | VAL_DIGITS*7 (14) | Byte digits, lowest nibble in the lowest 7 bits |

## Verification
The bench builds the block with the default 4-bit pointer, 8-bit bytes and active-high segments. These values keep all 16 locations and both wrap points within a few presses. This makes it practical to fill several locations with different bytes and walk back over them, so the reload after every step is checked against the stored contents. Byte wrap in both directions, held buttons, button combinations and a button held across reset are all exercised at this size. Every displayed digit is compared against glyphs derived from R10.

// File: rtl/memedit_pkg.sv
package memedit_pkg;
   localparam int NBTN = 4;

   // Bit positions of the button vector used inside the block.
   localparam int BTN_ADDR_UP = 0;
   localparam int BTN_ADDR_DN = 1;
   localparam int BTN_VAL_UP  = 2;
   localparam int BTN_VAL_DN  = 3;

   localparam int SEG_W = 7;

   function automatic int digits_for(input int bits);
      return (bits + 3) / 4;
   endfunction
endpackage

// File: rtl/memedit_keys.sv
module memedit_keys
   import memedit_pkg::*;
#(
   parameter int N = NBTN
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] act
);
   logic [N-1:0] prev_q;
   logic         solo;

   // Reset to all ones so a level held across reset is not taken as a press.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= lvl;
   end

   assign solo = ($countones(lvl) == 1);
   assign act  = solo ? (lvl & ~prev_q) : '0;
endmodule

// File: rtl/memedit_store.sv
module memedit_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cell_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
      end else if (we) begin
         cell_q[waddr] <= wdata;
      end
   end

   assign rdata = cell_q[raddr];
endmodule

// File: rtl/memedit_hexseg.sv
module memedit_hexseg
   import memedit_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [3:0]       nib,
   output logic [SEG_W-1:0] seg
);
   logic [SEG_W-1:0] lit;

   // Segment order g f e d c b a, one bit per segment.
   always_comb begin
      unique case (nib)
         4'h0: lit = 7'b0111111;
         4'h1: lit = 7'b0000110;
         4'h2: lit = 7'b1011011;
         4'h3: lit = 7'b1001111;
         4'h4: lit = 7'b1100110;
         4'h5: lit = 7'b1101101;
         4'h6: lit = 7'b1111101;
         4'h7: lit = 7'b0000111;
         4'h8: lit = 7'b1111111;
         4'h9: lit = 7'b1101111;
         4'hA: lit = 7'b1110111;
         4'hB: lit = 7'b1111100;
         4'hC: lit = 7'b0111001;
         4'hD: lit = 7'b1011110;
         4'hE: lit = 7'b1111001;
         default: lit = 7'b1110001;
      endcase
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign seg = ~lit;
      end else begin : g_high
         assign seg = lit;
      end
   endgenerate
endmodule

// File: rtl/memedit_top.sv
module memedit_top
   import memedit_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter bit SEG_ACTIVE_LOW = 1'b0,
   localparam int ADDR_DIGITS   = digits_for(ADDR_W),
   localparam int VAL_DIGITS    = digits_for(DATA_W)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       btn_addr_up,
   input  logic                       btn_addr_dn,
   input  logic                       btn_val_up,
   input  logic                       btn_val_dn,
   output logic [ADDR_DIGITS*SEG_W-1:0] seg_addr,
   output logic [VAL_DIGITS*SEG_W-1:0]  seg_val
);
   localparam int ADDR_PAD = ADDR_DIGITS * 4;
   localparam int VAL_PAD  = VAL_DIGITS * 4;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 12)
         else $error("memedit_top: ADDR_W out of range");
      assert (DATA_W >= 1 && DATA_W <= 32)
         else $error("memedit_top: DATA_W out of range");
   end

   logic [NBTN-1:0]   lvl;
   logic [NBTN-1:0]   act;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic [DATA_W-1:0] val_q;
   logic [DATA_W-1:0] val_edit;
   logic [DATA_W-1:0] rd_byte;
   logic              step;
   logic              edit;

   assign lvl[BTN_ADDR_UP] = btn_addr_up;
   assign lvl[BTN_ADDR_DN] = btn_addr_dn;
   assign lvl[BTN_VAL_UP]  = btn_val_up;
   assign lvl[BTN_VAL_DN]  = btn_val_dn;

   memedit_keys #(.N(NBTN)) u_keys (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .act   (act)
   );

   // Next pointer and edited byte; width truncation gives the wrap.
   always_comb begin
      addr_nxt = addr_q;
      if (act[BTN_ADDR_UP])      addr_nxt = ADDR_W'(addr_q + 1'b1);
      else if (act[BTN_ADDR_DN]) addr_nxt = ADDR_W'(addr_q - 1'b1);
   end

   always_comb begin
      val_edit = val_q;
      if (act[BTN_VAL_UP])      val_edit = DATA_W'(val_q + 1'b1);
      else if (act[BTN_VAL_DN]) val_edit = DATA_W'(val_q - 1'b1);
   end

   assign step = act[BTN_ADDR_UP] | act[BTN_ADDR_DN];
   assign edit = act[BTN_VAL_UP]  | act[BTN_VAL_DN];

   memedit_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (edit),
      .waddr (addr_q),
      .wdata (val_edit),
      .raddr (addr_nxt),
      .rdata (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         val_q  <= '0;
      end else begin
         addr_q <= addr_nxt;
         if (step)      val_q <= rd_byte;
         else if (edit) val_q <= val_edit;
      end
   end

   logic [ADDR_PAD-1:0] addr_wide;
   logic [VAL_PAD-1:0]  val_wide;

   assign addr_wide = ADDR_PAD'(addr_q);
   assign val_wide  = VAL_PAD'(val_q);

   generate
      for (genvar d = 0; d < ADDR_DIGITS; d++) begin : g_addr_dig
         memedit_hexseg #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_dec (
            .nib (addr_wide[d*4 +: 4]),
            .seg (seg_addr[d*SEG_W +: SEG_W])
         );
      end
      for (genvar d = 0; d < VAL_DIGITS; d++) begin : g_val_dig
         memedit_hexseg #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_dec (
            .nib (val_wide[d*4 +: 4]),
            .seg (seg_val[d*SEG_W +: SEG_W])
         );
      end
   endgenerate
endmodule

// File: rtl/memedit_chk.sv
module memedit_chk
   import memedit_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NBTN-1:0]   btns,
   input logic [ADDR_W-1:0] addr_q,
   input logic [DATA_W-1:0] val_q
);
   logic [NBTN-1:0] hist_q;
   logic [NBTN-1:0] fresh;
   logic            single;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '1;
      else        hist_q <= btns;
   end

   assign fresh  = btns & ~hist_q;
   assign single = ($countones(btns) == 1);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (addr_q == '0 && val_q == '0); // R1
      end
   end

   AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (single && fresh[BTN_ADDR_UP]) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R2
   AST_ADDR_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (single && fresh[BTN_ADDR_DN]) |=> addr_q == ADDR_W'($past(addr_q) - 1'b1)); // R3
   AST_VAL_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (single && fresh[BTN_VAL_UP]) |=> val_q == DATA_W'($past(val_q) + 1'b1) && $stable(addr_q)); // R5
   AST_VAL_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (single && fresh[BTN_VAL_DN]) |=> val_q == DATA_W'($past(val_q) - 1'b1) && $stable(addr_q)); // R6
   AST_HELD_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh == '0) |=> $stable(addr_q) && $stable(val_q)); // R7
   AST_MULTI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(btns) > 1) |=> $stable(addr_q) && $stable(val_q)); // R8
endmodule

bind memedit_top memedit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .btns   ({btn_val_dn, btn_val_up, btn_addr_dn, btn_addr_up}),
   .addr_q (addr_q),
   .val_q  (val_q)
);

// File: tb/sim_memedit_top.sv
`timescale 1ns/1ps
module sim_memedit_top;
   localparam logic [3:0] AUP = 4'b0001;
   localparam logic [3:0] ADN = 4'b0010;
   localparam logic [3:0] VUP = 4'b0100;
   localparam logic [3:0] VDN = 4'b1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic [3:0]  btn = 4'b0000;
   logic [6:0]  seg_addr;
   logic [13:0] seg_val;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   memedit_top u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .btn_addr_up (btn[0]),
      .btn_addr_dn (btn[1]),
      .btn_val_up  (btn[2]),
      .btn_val_dn  (btn[3]),
      .seg_addr    (seg_addr),
      .seg_val     (seg_val)
   );

   // Reference model built from the requirements
   logic [7:0] mem_m [16];
   logic [3:0] addr_m = 4'h0;
   logic [7:0] val_m  = 8'h00;

   typedef struct {
      logic [3:0] a;
      logic [7:0] v;
      string      req;
   } exp_t;
   exp_t sbq [$];
   event smp_ev;

   function automatic logic [6:0] glyph(input logic [3:0] h);
      case (h)
         4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
         4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
         4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
         4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
      endcase
   endfunction

   // Monitor: pops expected items and compares the digits
   initial begin
      forever begin
         @(smp_ev);
         while (sbq.size() > 0) begin
            exp_t e;
            logic [13:0] ev;
            e  = sbq.pop_front();
            ev = {glyph(e.v[7:4]), glyph(e.v[3:0])};
            checks++;
            if (seg_addr !== glyph(e.a)) begin
               errors++;
               $display("FAIL %s addr digit: got %h expected %h (addr %h)", e.req, seg_addr, glyph(e.a), e.a);
            end
            checks++;
            if (seg_val !== ev) begin
               errors++;
               $display("FAIL %s value digits: got %h expected %h (byte %h)", e.req, seg_val, ev, e.v);
            end
         end
      end
   end

   task automatic expect_now(input string req);
      sbq.push_back('{a: addr_m, v: val_m, req: req});
      -> smp_ev;
      #0.1;
   endtask

   task automatic model_apply(input logic [3:0] m);
      if ($countones(m) == 1) begin
         case (m)
            AUP: begin addr_m = addr_m + 4'd1; val_m = mem_m[addr_m]; end
            ADN: begin addr_m = addr_m - 4'd1; val_m = mem_m[addr_m]; end
            VUP: begin val_m = val_m + 8'd1; mem_m[addr_m] = val_m; end
            default: begin val_m = val_m - 8'd1; mem_m[addr_m] = val_m; end
         endcase
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) mem_m[i] = 8'h00;
      addr_m = 4'h0;
      val_m  = 8'h00;
   endtask

   // Driver: hold a button pattern for some cycles, release, then expect
   task automatic press(input logic [3:0] m, input int hold, input string req);
      @(negedge clk);
      btn = m;
      repeat (hold) @(negedge clk);
      btn = 4'b0000;
      @(negedge clk);
      model_apply(m);
      expect_now(req);
   endtask

   task automatic press_n(input logic [3:0] m, input int n, input string req);
      for (int i = 0; i < n; i++) press(m, 1, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      model_reset();
      expect_now("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      expect_now("R1 after reset");
   endtask

   initial begin
      #1 rst_n = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      expect_now("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      expect_now("R1 reset state released");

      // Value editing and byte wrap in both directions
      press_n(VUP, 3, "R5 increment");
      press_n(VDN, 4, "R6 decrement wrap 00->FF");
      press(VUP, 1, "R5 increment wrap FF->00");
      press_n(VUP, 2, "R5 increment");

      // Pointer wrap downward, reload of an untouched location
      press(ADN, 1, "R3 pointer wrap 0->F");
      press_n(VUP, 7, "R5 edit at F");
      press(AUP, 1, "R2 pointer wrap F->0 with R4 reload");
      press(ADN, 1, "R3 step back with R4 reload");

      // Held button acts only once
      press(VUP, 6, "R7 held value button");
      press(AUP, 5, "R7 held pointer button");

      // Combinations are ignored
      press(VUP | ADN, 2, "R8 two buttons together");
      press(4'b1111, 1, "R8 all buttons together");
      @(negedge clk); btn = AUP;
      @(negedge clk); model_apply(AUP); btn = AUP | VUP;
      @(negedge clk); btn = AUP;
      @(negedge clk); btn = 4'b0000;
      @(negedge clk); expect_now("R8 second button while first held");

      // Fill several locations, then walk back over them
      for (int k = 1; k <= 5; k++) begin
         press(AUP, 1, "R2 step forward with R4 reload");
         press_n(VUP, k * 3, "R5 fill location");
      end
      for (int k = 0; k < 8; k++) press(ADN, 1, "R4 reload on backward walk");
      for (int k = 0; k < 17; k++) press(AUP, 1, "R4 reload on forward walk");

      // Reset clears all locations
      do_reset();
      for (int k = 0; k < 16; k++) press(AUP, 1, "R1 location cleared by reset");

      // Button held while reset is released
      @(negedge clk);
      btn = VUP;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      btn = 4'b0000;
      @(negedge clk);
      model_reset();
      expect_now("R9 held across reset");
      press(VUP, 1, "R9 fresh press after reset");

      // Glyph coverage on the value digits
      for (int k = 0; k < 16; k++) press_n(VUP, 17, "R10 glyph");

      #1;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule